// File: doc/BRIEF.md
# Dual Accumulator Saturation Unit

This block is the write-back stage for a pair of signed 40-bit accumulators, called A and B, that take results from a 40-bit arithmetic unit. Each cycle it can accept one raw sum, carried one bit wider than an accumulator so that the true sign is never lost. A select input names the target accumulator. The block then either limits the sum to a saturation point or lets it wrap, writes the outcome into the target, and updates that accumulator's status flags.

Each accumulator has its own saturation enable. A shared mode input chooses between two saturation points:

- **Wide point:** the full 40-bit signed range (a 9.31 value).
- **Narrow point:** the 32-bit signed range (a 1.31 value). The upper eight bits then only carry sign extension.

Status per accumulator:

- A sticky saturation flag records any clamp until it is cleared.
- A guard flag shows whether the last result spilled into the upper eight bits. The block also outputs the OR of the two guard flags.
- When saturation is off and the sum overruns bit 39, a trap pulse can be requested.

A second write port loads an accumulator directly. It bypasses every check and leaves all status flags alone.

Top module: `dual_acc_sat`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, both accumulators, all saturation flags, all guard flags, `ovf_any` and `trap_req` read zero.
- R2: All state is registered. An update accepted at a clock edge appears on the outputs after that edge. With saturation enabled and `sat_wide`=1, a sum above 2^39-1 writes 0x7FFFFFFFFF, a sum below -2^39 writes 0x8000000000, and a sum inside the range is written unchanged.
- R3: With saturation enabled and `sat_wide`=0, a sum above 2^31-1 writes 0x007FFFFFFF, and a sum below -2^31 writes 0xFF80000000. The bounds 2^31-1 and -2^31 themselves are written unchanged.
- R4: With saturation disabled for the target, the accumulator takes bits 39..0 of the sum, so the sign may be lost.
- R5: A clamp sets the target's sticky flag (`sat_a` or `sat_b`). The flag holds until its clear input (`sat_clr_a`, `sat_clr_b`) is high at an edge. When a clear and a clamp meet at the same edge, the flag stays set.
- R6: After each update through the arithmetic path, the target's guard flag equals 1 exactly when bits 39..31 of the written value are not all equal. It keeps that value until the next such update. `ovf_any` is the OR of `ovf_a` and `ovf_b`. A saturating narrow-mode update therefore always leaves the guard flag at 0.
- R7: `trap_req` is high for exactly the cycle after an update where all of these hold: saturation is disabled for the target, `trap_en` is 1, and bit 40 of the sum differs from bit 39.
- R8: A direct write (`wr_vld`, `wr_sel`: 0=A, 1=B) loads `wr_data` unchanged. It changes no flag and raises no trap. If the arithmetic path updates the same accumulator at the same edge, the arithmetic result is written.
- R9: `upd_sel`=0 targets A and `upd_sel`=1 targets B. An update uses only the target's saturation enable, and the other accumulator and its flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_vld | input | 1 | Arithmetic-path update valid |
| upd_sel | input | 1 | Update target: 0=A, 1=B |
| upd_sum | input | ACC_W+1 | Raw signed sum, one bit wider than an accumulator |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_wide | input | 1 | 1 = wide 40-bit point, 0 = narrow 32-bit point |
| trap_en | input | 1 | Enables trap request on unsaturated overrun |
| sat_clr_a | input | 1 | Clears sticky flag of A |
| sat_clr_b | input | 1 | Clears sticky flag of B |
| wr_vld | input | 1 | Direct write valid |
| wr_sel | input | 1 | Direct write target: 0=A, 1=B |
| wr_data | input | ACC_W | Direct write value |
| acc_a | output | ACC_W | Accumulator A |
| acc_b | output | ACC_W | Accumulator B |
| sat_a | output | 1 | Sticky saturation flag of A |
| sat_b | output | 1 | Sticky saturation flag of B |
| ovf_a | output | 1 | Guard-bit overflow flag of A |
| ovf_b | output | 1 | Guard-bit overflow flag of B |
| ovf_any | output | 1 | OR of both guard flags |
| trap_req | output | 1 | One-cycle overrun trap request |

## Verification
Some properties are checked on every cycle:

- The sticky flags hold until cleared.
- A saturating narrow-mode update never leaves a guard flag set.
- A direct write loads its data and leaves the flags unchanged.
- A wide-mode overrun writes one of the two extreme values.
- A trap pulse is always preceded by an unsaturated update with the trap enabled.

Other behaviour can only be shown by the bench's scenarios against its arithmetic model:

- the exact clamp value chosen for each sign and mode;
- the exact values at the narrow bounds;
- clear-versus-set at the same edge;
- the update-over-write collision;
- that one accumulator's enable never affects the other.

// File: rtl/dsat_pkg.sv
package dsat_pkg;

   typedef enum logic [1:0] {
      CLAMP_NONE = 2'd0,
      CLAMP_POS  = 2'd1,
      CLAMP_NEG  = 2'd2
   } clamp_e;

   localparam int unsigned NUM_ACC = 2;

endpackage

// File: rtl/dsat_limit.sv
module dsat_limit #(
   parameter int unsigned ACC_W    = 40,
   parameter int unsigned NARROW_W = 32
) (
   input  logic [ACC_W:0]   sum_i,
   input  logic             sat_en_i,
   input  logic             wide_i,
   output logic [ACC_W-1:0] res_o,
   output dsat_pkg::clamp_e clamp_o,
   output logic             wrap_ovf_o,
   output logic             guard_ovf_o
);
   import dsat_pkg::*;

   localparam int unsigned SUM_W  = ACC_W + 1;
   localparam int unsigned EXT_W  = ACC_W - NARROW_W + 1;
   localparam int unsigned GUARD_W = ACC_W - NARROW_W + 1;

   localparam logic [ACC_W-1:0] WIDE_POS   = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] WIDE_NEG   = {1'b1, {(ACC_W-1){1'b0}}};
   localparam logic [ACC_W-1:0] NARROW_POS = {{EXT_W{1'b0}}, {(NARROW_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NARROW_NEG = {{EXT_W{1'b1}}, {(NARROW_W-1){1'b0}}};

   logic                      wide_fit;
   logic                      narrow_fit;
   logic                      fits;
   logic [SUM_W-NARROW_W:0]   narrow_top;
   logic [GUARD_W-1:0]        res_guard;

   assign wide_fit   = (sum_i[SUM_W-1] == sum_i[ACC_W-1]);
   assign narrow_top = sum_i[SUM_W-1:NARROW_W-1];
   assign narrow_fit = (&narrow_top) | ~(|narrow_top);
   assign fits       = wide_i ? wide_fit : narrow_fit;

   always_comb begin
      clamp_o = CLAMP_NONE;
      res_o   = sum_i[ACC_W-1:0];
      if (sat_en_i && !fits) begin
         if (sum_i[SUM_W-1]) begin
            clamp_o = CLAMP_NEG;
            res_o   = wide_i ? WIDE_NEG : NARROW_NEG;
         end else begin
            clamp_o = CLAMP_POS;
            res_o   = wide_i ? WIDE_POS : NARROW_POS;
         end
      end
   end

   assign wrap_ovf_o  = ~wide_fit;
   assign res_guard   = res_o[ACC_W-1:NARROW_W-1];
   assign guard_ovf_o = ~((&res_guard) | ~(|res_guard));

endmodule

// File: rtl/dsat_slot.sv
module dsat_slot #(
   parameter int unsigned ACC_W    = 40,
   parameter int unsigned NARROW_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_hit_i,
   input  logic             narrow_sat_i,
   input  logic [ACC_W-1:0] res_i,
   input  logic             clamp_hit_i,
   input  logic             guard_ovf_i,
   input  logic             wr_hit_i,
   input  logic [ACC_W-1:0] wr_data_i,
   input  logic             sat_clr_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             sat_o,
   output logic             ovf_o
);

   logic [ACC_W-1:0] acc_q;
   logic             sat_q;
   logic             ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (upd_hit_i) begin
         acc_q <= res_i;
      end else if (wr_hit_i) begin
         acc_q <= wr_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sat_q <= 1'b0;
      end else if (upd_hit_i && clamp_hit_i) begin
         sat_q <= 1'b1;
      end else if (sat_clr_i) begin
         sat_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (upd_hit_i) begin
         ovf_q <= guard_ovf_i;
      end
   end

   assign acc_o = acc_q;
   assign sat_o = sat_q;
   assign ovf_o = ovf_q;

   // R5
   sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sat_q && !sat_clr_i |=> sat_q);

   // R6
   narrow_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_hit_i && narrow_sat_i |=> !ovf_q);

   // R8
   wr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit_i && !upd_hit_i && !sat_clr_i |=> $stable(sat_q) && $stable(ovf_q));

   // R8
   wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit_i && !upd_hit_i |=> acc_q == $past(wr_data_i));

endmodule

// File: rtl/dual_acc_sat.sv
module dual_acc_sat #(
   parameter int unsigned ACC_W    = 40,
   parameter int unsigned NARROW_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_vld,
   input  logic             upd_sel,
   input  logic [ACC_W:0]   upd_sum,
   input  logic             sat_en_a,
   input  logic             sat_en_b,
   input  logic             sat_wide,
   input  logic             trap_en,
   input  logic             sat_clr_a,
   input  logic             sat_clr_b,
   input  logic             wr_vld,
   input  logic             wr_sel,
   input  logic [ACC_W-1:0] wr_data,
   output logic [ACC_W-1:0] acc_a,
   output logic [ACC_W-1:0] acc_b,
   output logic             sat_a,
   output logic             sat_b,
   output logic             ovf_a,
   output logic             ovf_b,
   output logic             ovf_any,
   output logic             trap_req
);
   import dsat_pkg::*;

   generate
      if (NARROW_W < 2 || NARROW_W >= ACC_W) begin : g_bad_narrow
         $error("dual_acc_sat: NARROW_W must lie in [2, ACC_W-1]");
      end
   endgenerate

   logic             sat_en_eff;
   logic [ACC_W-1:0] lim_res;
   clamp_e           lim_clamp;
   logic             lim_wrap;
   logic             lim_guard;
   logic             trap_q;

   logic [NUM_ACC-1:0] sat_en_vec;
   logic [NUM_ACC-1:0] clr_vec;
   logic [NUM_ACC-1:0] sat_vec;
   logic [NUM_ACC-1:0] ovf_vec;
   logic [ACC_W-1:0]   acc_vec [NUM_ACC];

   assign sat_en_vec = {sat_en_b, sat_en_a};
   assign clr_vec    = {sat_clr_b, sat_clr_a};
   assign sat_en_eff = sat_en_vec[upd_sel];

   dsat_limit #(
      .ACC_W    (ACC_W),
      .NARROW_W (NARROW_W)
   ) i_limit (
      .sum_i       (upd_sum),
      .sat_en_i    (sat_en_eff),
      .wide_i      (sat_wide),
      .res_o       (lim_res),
      .clamp_o     (lim_clamp),
      .wrap_ovf_o  (lim_wrap),
      .guard_ovf_o (lim_guard)
   );

   generate
      for (genvar g = 0; g < NUM_ACC; g++) begin : g_slot
         logic upd_hit;
         logic wr_hit;
         assign upd_hit = upd_vld && (upd_sel == 1'(g));
         assign wr_hit  = wr_vld && (wr_sel == 1'(g));

         dsat_slot #(
            .ACC_W    (ACC_W),
            .NARROW_W (NARROW_W)
         ) i_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .upd_hit_i    (upd_hit),
            .narrow_sat_i (sat_en_eff && !sat_wide),
            .res_i        (lim_res),
            .clamp_hit_i  (lim_clamp != CLAMP_NONE),
            .guard_ovf_i  (lim_guard),
            .wr_hit_i     (wr_hit),
            .wr_data_i    (wr_data),
            .sat_clr_i    (clr_vec[g]),
            .acc_o        (acc_vec[g]),
            .sat_o        (sat_vec[g]),
            .ovf_o        (ovf_vec[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_q <= 1'b0;
      end else begin
         trap_q <= upd_vld && !sat_en_eff && trap_en && lim_wrap;
      end
   end

   assign acc_a    = acc_vec[0];
   assign acc_b    = acc_vec[1];
   assign sat_a    = sat_vec[0];
   assign sat_b    = sat_vec[1];
   assign ovf_a    = ovf_vec[0];
   assign ovf_b    = ovf_vec[1];
   assign ovf_any  = |ovf_vec;
   assign trap_req = trap_q;

   // R7
   trap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(upd_vld && trap_en && !sat_en_eff));

   // R2
   wide_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_vld && !upd_sel && sat_en_a && sat_wide && (upd_sum[ACC_W] != upd_sum[ACC_W-1])
      |=> (acc_a == {1'b0, {(ACC_W-1){1'b1}}}) || (acc_a == {1'b1, {(ACC_W-1){1'b0}}}));

   // R9
   other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_vld && upd_sel && !(wr_vld && !wr_sel) |=> $stable(acc_a));

endmodule

// File: tb/test_dual_acc_sat.sv
`timescale 1ns/1ps
module test_dual_acc_sat;

   localparam int ACC_W = 40;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             upd_vld, upd_sel, sat_en_a, sat_en_b, sat_wide, trap_en;
   logic             sat_clr_a, sat_clr_b, wr_vld, wr_sel;
   logic [ACC_W:0]   upd_sum;
   logic [ACC_W-1:0] wr_data;
   logic [ACC_W-1:0] acc_a, acc_b;
   logic             sat_a, sat_b, ovf_a, ovf_b, ovf_any, trap_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [ACC_W-1:0] m_acc [2];
   logic             m_sat [2];
   logic             m_ovf [2];
   logic             m_trap;

   always #2.5 clk = ~clk;

   dual_acc_sat i_dual_acc_sat (
      .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .upd_sel(upd_sel),
      .upd_sum(upd_sum), .sat_en_a(sat_en_a), .sat_en_b(sat_en_b),
      .sat_wide(sat_wide), .trap_en(trap_en), .sat_clr_a(sat_clr_a),
      .sat_clr_b(sat_clr_b), .wr_vld(wr_vld), .wr_sel(wr_sel),
      .wr_data(wr_data), .acc_a(acc_a), .acc_b(acc_b), .sat_a(sat_a),
      .sat_b(sat_b), .ovf_a(ovf_a), .ovf_b(ovf_b), .ovf_any(ovf_any),
      .trap_req(trap_req)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic compare(string req);
      chk(req, "acc_a", 64'(acc_a), 64'(m_acc[0]));
      chk(req, "acc_b", 64'(acc_b), 64'(m_acc[1]));
      chk(req, "sat_a", 64'(sat_a), 64'(m_sat[0]));
      chk(req, "sat_b", 64'(sat_b), 64'(m_sat[1]));
      chk(req, "ovf_a", 64'(ovf_a), 64'(m_ovf[0]));
      chk(req, "ovf_b", 64'(ovf_b), 64'(m_ovf[1]));
      chk(req, "ovf_any", 64'(ovf_any), 64'(m_ovf[0] | m_ovf[1]));
      chk(req, "trap_req", 64'(trap_req), 64'(m_trap));
   endtask

   function automatic logic in_range(longint v, int bits);
      longint hi = (64'sd1 <<< (bits - 1)) - 1;
      longint lo = -(64'sd1 <<< (bits - 1));
      return (v <= hi) && (v >= lo);
   endfunction

   // one clock: model computes next state from the driven inputs, then compare
   task automatic step(string req);
      logic [ACC_W-1:0] n_acc [2];
      logic             n_sat [2];
      logic             n_ovf [2];
      logic             n_trap;
      n_acc = m_acc; n_sat = m_sat; n_ovf = m_ovf; n_trap = 1'b0;
      if (wr_vld) n_acc[wr_sel] = wr_data;
      if (sat_clr_a) n_sat[0] = 1'b0;
      if (sat_clr_b) n_sat[1] = 1'b0;
      if (upd_vld) begin
         longint sv = longint'($signed(upd_sum));
         int     t  = upd_sel ? 1 : 0;
         logic   en = upd_sel ? sat_en_b : sat_en_a;
         int     bits = sat_wide ? 40 : 32;
         longint hi = (64'sd1 <<< (bits - 1)) - 1;
         longint lo = -(64'sd1 <<< (bits - 1));
         logic [ACC_W-1:0] r;
         if (en && sv > hi) begin
            r = hi[ACC_W-1:0]; n_sat[t] = 1'b1;
         end else if (en && sv < lo) begin
            r = lo[ACC_W-1:0]; n_sat[t] = 1'b1;
         end else begin
            r = upd_sum[ACC_W-1:0];
         end
         n_acc[t] = r;
         n_ovf[t] = !in_range(longint'($signed(r)), 32);
         n_trap   = !en && trap_en && !in_range(sv, 40);
      end
      @(posedge clk);
      #1;
      m_acc = n_acc; m_sat = n_sat; m_ovf = n_ovf; m_trap = n_trap;
      compare(req);
   endtask

   task automatic idle();
      upd_vld = 0; wr_vld = 0; sat_clr_a = 0; sat_clr_b = 0;
   endtask

   task automatic alu(logic sel, longint v, string req);
      idle();
      upd_vld = 1; upd_sel = sel; upd_sum = v[ACC_W:0];
      step(req);
      idle();
   endtask

   initial begin
      rst_n = 0; upd_sel = 0; upd_sum = '0; sat_en_a = 0; sat_en_b = 0;
      sat_wide = 1; trap_en = 0; wr_sel = 0; wr_data = '0;
      idle();
      for (int i = 0; i < 2; i++) begin
         m_acc[i] = '0; m_sat[i] = 0; m_ovf[i] = 0;
      end
      m_trap = 0;
      repeat (3) @(posedge clk);
      #1;
      compare("R1");
      rst_n = 1;
      step("R1");

      // R2 wide saturation
      sat_en_a = 1; sat_en_b = 1; sat_wide = 1;
      alu(0, (64'sd1 <<< 39), "R2");
      alu(0, -(64'sd1 <<< 39) - 5, "R2");
      alu(0, (64'sd1 <<< 39) - 1, "R2");
      alu(1, 64'sd12345, "R2");

      // R3 narrow saturation and bounds
      sat_wide = 0;
      alu(0, (64'sd1 <<< 31) - 1, "R3");
      alu(0, (64'sd1 <<< 31), "R3");
      alu(1, -(64'sd1 <<< 31), "R3");
      alu(1, -(64'sd1 <<< 31) - 1, "R3");
      alu(1, (64'sd1 <<< 38), "R6");

      // R5 clear, and clear versus set at the same edge
      idle(); sat_clr_a = 1; step("R5");
      idle(); step("R5");
      idle(); upd_vld = 1; upd_sel = 1; upd_sum = 41'((64'sd1 <<< 33)); sat_clr_b = 1;
      step("R5");
      idle();

      // R4 / R7 wrap with and without trap
      sat_en_a = 0; sat_wide = 1; trap_en = 0;
      alu(0, (64'sd1 <<< 39) + 7, "R4");
      trap_en = 1;
      alu(0, -(64'sd1 <<< 39) - 1, "R7");
      step("R7");
      alu(0, (64'sd1 <<< 35), "R6");
      alu(0, 64'sd100, "R6");

      // R9 independent enables: A off, B on
      sat_en_a = 0; sat_en_b = 1;
      alu(1, (64'sd1 <<< 39) + 3, "R9");
      alu(0, (64'sd1 <<< 39) + 3, "R9");

      // R8 direct write, flags untouched, collision
      idle(); wr_vld = 1; wr_sel = 0; wr_data = 40'hFF_0000_0001; step("R8");
      idle(); wr_vld = 1; wr_sel = 1; wr_data = 40'h12_3456_789A;
      upd_vld = 1; upd_sel = 1; upd_sum = 41'd77; step("R8");
      idle(); wr_vld = 1; wr_sel = 1; wr_data = 40'h80_0000_0000; step("R8");

      // mixed sweep
      for (int k = 0; k < 400; k++) begin
         int mode = int'($urandom % 4);
         longint v;
         idle();
         sat_en_a = 1'($urandom); sat_en_b = 1'($urandom);
         sat_wide = 1'($urandom); trap_en = 1'($urandom);
         sat_clr_a = ($urandom % 8) == 0; sat_clr_b = ($urandom % 8) == 0;
         wr_vld = ($urandom % 6) == 0; wr_sel = 1'($urandom);
         wr_data = {8'($urandom), 32'($urandom)};
         upd_vld = ($urandom % 4) != 0; upd_sel = 1'($urandom);
         case (mode)
            0: v = longint'(int'($urandom)) >>> 4;
            1: v = (64'sd1 <<< 39) - 2 + longint'($urandom % 4);
            2: v = -(64'sd1 <<< 31) - 2 + longint'($urandom % 4);
            default: v = longint'({$urandom, $urandom}) >>> 23;
         endcase
         if (($urandom % 2) == 1) v = -v;
         upd_sum = v[ACC_W:0];
         step("R9");
      end
      idle();
      step("R6");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule